// File: doc/BRIEF.md
# Dual Prescaled Tick Generator

This block derives two independent count-enable strobes, A and B, from the master clock. Each strobe comes from a generator built as a power-of-two prescaler followed by an 8-bit linear divider. Both generators are configured from one 32-bit mode word. Each 16-bit half of the word belongs to one generator, and a generator whose divider field is zero stays silent. PWM channel counters downstream use each tick as their count enable.

Each generator also has a half-rate strobe. It fires on every second tick, so a channel that counts up and down in center-aligned operation sees a period twice as long as a channel that counts in one direction. When a write changes one half of the mode word, only that generator restarts from zero. The other generator keeps its phase.

Top module: `pwm_dual_tick_gen`

## Requirements
- R1: When `mode_we` is high at a clock edge, `mode_wdata` is stored in full, and `mode_word` shows the stored value from the next cycle.
- R2: Generator A (`tick[0]`, `tick_half[0]`) is configured by mode bits 15:0 and generator B (`tick[1]`, `tick_half[1]`) by bits 31:16. Within a half, bits 7:0 are the divider `div`, bits 11:8 are the prescale exponent `pre`, and bits 15:12 do not affect the period.
- R3: With `div` nonzero, a generator's tick is high in the cycle after every edge whose count since the restart edge is a multiple of N = 2^pre × div. The restart edge is the last edge that captured a change to its half, or the last reset edge.
- R4: A tick lasts one cycle when N > 1. With `div` = 1 and `pre` = 0, the tick is high on every cycle.
- R5: A generator whose `div` field is 0 never raises its tick or its half-rate strobe.
- R6: A `pre` value above 10 produces the same period as `pre` = 10.
- R7: A write that leaves a half's 16 bits unchanged does not disturb that generator's phase. A write that changes any of those bits, including bits 15:12, restarts the generator from zero with both of its outputs low.
- R8: The half-rate strobe is high together with every second tick after a restart, so its period is 2N.
- R9: Synchronous reset clears the mode word and all tick outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 32 | Mode word write value |
| mode_word | output | 32 | Stored mode word |
| tick | output | 2 | Per-generator tick (bit 0 = A, bit 1 = B) |
| tick_half | output | 2 | Per-generator half-rate tick for center-aligned counting |

## Verification
Directed settings check the main function at several points. The fastest setting (every cycle) is paired with an off generator. Two halves with different periods show that the fields are not swapped. The 255 divider probes the top of the divider range, and prescale values 11 and 15 must match the 1024-cycle and 2048-cycle periods of the clamped exponent. Rewriting an unchanged value and then changing only bits 15:12 separates "no restart" from "restart" at the same period. Random halves with small periods, some zero dividers and some unchanged halves then place restarts at arbitrary phases. This exercises the independence of A and B and the alternation of the half-rate strobe.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  localparam int unsigned DIV_W_DEF   = 8;
  localparam int unsigned PRE_W_DEF   = 4;
  localparam int unsigned PRE_MAX_DEF = 10;
  localparam int unsigned HALF_W_DEF  = 16;
  localparam int unsigned NUM_GEN_DEF = 2;
  localparam int unsigned WORD_W_DEF  = HALF_W_DEF * NUM_GEN_DEF;
endpackage

// File: rtl/pwm_tick_prescaler.sv
module pwm_tick_prescaler #(
  parameter int unsigned PRE_W   = pwm_tick_pkg::PRE_W_DEF,
  parameter int unsigned PRE_MAX = pwm_tick_pkg::PRE_MAX_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_exp,
  output logic             pre_end
);
  localparam int unsigned CNT_W = (PRE_MAX > 0) ? PRE_MAX : 1;
  localparam int unsigned SH_W  = CNT_W + 1;

  logic [CNT_W-1:0] pc;
  logic [CNT_W-1:0] lim;
  logic [SH_W-1:0]  span;
  logic [PRE_W-1:0] pre_eff;

  // exponent saturates at PRE_MAX
  always_comb begin
    pre_eff = (pre_exp > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : pre_exp;
    span    = SH_W'(1) << pre_eff;
    lim     = CNT_W'(span - SH_W'(1));
    pre_end = run && (pc == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pc <= '0;
    end else if (run) begin
      pc <= pre_end ? '0 : pc + 1'b1;
    end
  end

  AST_PRESC_IN_RANGE: assert property (@(posedge clk) disable iff (rst) (pc <= lim)); // R3
endmodule

// File: rtl/pwm_tick_divider.sv
module pwm_tick_divider #(
  parameter int unsigned DIV_W = pwm_tick_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             pre_end,
  input  logic [DIV_W-1:0] div,
  output logic             tick_q,
  output logic             half_q
);
  logic [DIV_W-1:0] dc;
  logic             phase;
  logic             last;

  assign last = (dc == (div - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      dc     <= '0;
      phase  <= 1'b0;
      tick_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      half_q <= 1'b0;
      if (pre_end) begin
        if (last) begin
          dc     <= '0;
          tick_q <= 1'b1;
          half_q <= phase;
          phase  <= ~phase;
        end else begin
          dc <= dc + 1'b1;
        end
      end
    end
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst) (div == '0) |=> !tick_q); // R5
  AST_HALF_ON_TICK: assert property (@(posedge clk) disable iff (rst) half_q |-> tick_q); // R8
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst) restart |=> (!tick_q && !half_q)); // R7
endmodule

// File: rtl/pwm_dual_tick_gen.sv
module pwm_dual_tick_gen #(
  parameter int unsigned DIV_W   = pwm_tick_pkg::DIV_W_DEF,
  parameter int unsigned PRE_W   = pwm_tick_pkg::PRE_W_DEF,
  parameter int unsigned PRE_MAX = pwm_tick_pkg::PRE_MAX_DEF,
  parameter int unsigned HALF_W  = pwm_tick_pkg::HALF_W_DEF,
  parameter int unsigned NUM_GEN = pwm_tick_pkg::NUM_GEN_DEF,
  localparam int unsigned WORD_W = HALF_W * NUM_GEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [WORD_W-1:0] mode_wdata,
  output logic [WORD_W-1:0] mode_word,
  output logic [NUM_GEN-1:0] tick,
  output logic [NUM_GEN-1:0] tick_half
);
  logic [WORD_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q <= mode_wdata;
    end
  end

  assign mode_word = mode_q;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic [HALF_W-1:0] half_now;
    logic [HALF_W-1:0] half_new;
    logic              restart;
    logic [DIV_W-1:0]  div;
    logic [PRE_W-1:0]  pre;
    logic              run;
    logic              pre_end;

    assign half_now = mode_q[g*HALF_W +: HALF_W];
    assign half_new = mode_wdata[g*HALF_W +: HALF_W];
    assign restart  = mode_we && (half_new != half_now);
    assign div      = half_now[DIV_W-1:0];
    assign pre      = half_now[DIV_W +: PRE_W];
    assign run      = (div != '0);

    pwm_tick_prescaler #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_pre (
      .clk(clk), .rst(rst), .restart(restart), .run(run),
      .pre_exp(pre), .pre_end(pre_end)
    );

    pwm_tick_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .restart(restart), .pre_end(pre_end),
      .div(div), .tick_q(tick[g]), .half_q(tick_half[g])
    );

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
      (tick[g] && !(div == DIV_W'(1) && pre == '0) && !mode_we) |=> !tick[g]); // R4
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst) mode_we |=> (mode_q == $past(mode_wdata))); // R1
  AST_MODE_CLEAR: assert property (@(posedge clk) rst |=> (mode_q == '0 && tick == '0 && tick_half == '0)); // R9
endmodule

// File: tb/pwm_dual_tick_gen_tb.sv
module pwm_dual_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_we = 1'b0;
  logic [31:0] mode_wdata = '0;
  logic [31:0] mode_word;
  logic [1:0]  tick;
  logic [1:0]  tick_half;

  int vectors = 0;
  int fails = 0;
  string note = "R9 reset";
  bit started = 1'b0;
  bit done = 1'b0;

  logic [31:0] m_mode = '0;
  int cnt [2];

  always #10 clk = ~clk;

  pwm_dual_tick_gen dut_i (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mode_word(mode_word), .tick(tick), .tick_half(tick_half)
  );

  function automatic longint period_of(input logic [15:0] h);
    int p;
    p = int'(h[11:8]);
    if (p > 10) p = 10;
    return longint'(h[7:0]) * (longint'(1) << p);
  endfunction

  function automatic bit exp_fire(input logic [15:0] h, input int c, input int mult);
    longint n;
    n = period_of(h) * mult;
    if (n == 0 || c <= 0) return 1'b0;
    return (longint'(c) % n) == 0;
  endfunction

  function automatic string tag_of(input logic [15:0] h);
    if (h[7:0] == 8'd0) return "R5";
    if (h[11:8] > 4'd10) return "R6";
    if (period_of(h) == 1) return "R4";
    return "R3";
  endfunction

  // reference model: edges since each generator's last restart
  always @(posedge clk) begin
    if (rst) begin
      m_mode = '0;
      cnt[0] = 0;
      cnt[1] = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (mode_we && (mode_wdata[i*16 +: 16] != m_mode[i*16 +: 16])) cnt[i] = 0;
        else cnt[i] = cnt[i] + 1;
      end
      if (mode_we) m_mode = mode_wdata;
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (mode_word !== m_mode) begin
        fails++;
        $display("FAIL R1 [%s] mode_word got %h exp %h", note, mode_word, m_mode);
      end
      for (int i = 0; i < 2; i++) begin
        logic [15:0] h;
        bit et, eh;
        h  = m_mode[i*16 +: 16];
        et = exp_fire(h, cnt[i], 1);
        eh = exp_fire(h, cnt[i], 2);
        vectors += 2;
        if (tick[i] !== et) begin
          fails++;
          $display("FAIL %s R2 [%s] gen%0d tick got %b exp %b", tag_of(h), note, i, tick[i], et);
        end
        if (tick_half[i] !== eh) begin
          fails++;
          $display("FAIL R8 [%s] gen%0d tick_half got %b exp %b", note, i, tick_half[i], eh);
        end
      end
    end
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    mode_we = 1'b1;
    mode_wdata = v;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] cur;
    void'($urandom(32'h5eed_1234));
    run(3);
    rst = 1'b0;
    // R9 explicit reset-state check
    @(negedge clk);
    vectors++;
    if (mode_word !== 32'h0 || tick !== 2'b00 || tick_half !== 2'b00) begin
      fails++;
      $display("FAIL R9 reset state got %h/%b/%b exp 0/00/00", mode_word, tick, tick_half);
    end
    note = "R4 R5 fastest and off";
    wr(32'h0000_0001); run(20);
    note = "R2 R3 split halves";
    wr(32'h0105_0203); run(120);
    note = "R7 rewrite same value";
    run(5); wr(32'h0105_0203); run(60);
    note = "R7 upper bits change restarts";
    wr(32'h0105_F203); run(60);
    note = "R3 max divider";
    wr(32'h0001_00FF); run(600);
    note = "R6 prescale clamp";
    wr(32'h0F02_0B01); run(4200);
    note = "R1 random";
    cur = 32'h0105_F203;
    for (int s = 0; s < 40; s++) begin
      for (int i = 0; i < 2; i++) begin
        if (($urandom % 4) != 0) begin
          logic [15:0] h;
          h[7:0]   = 8'($urandom % 13);
          h[11:8]  = 4'($urandom % 4);
          h[15:12] = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
          cur[i*16 +: 16] = h;
        end
      end
      wr(cur);
      run(30 + int'($urandom % 200));
    end
    finish_run();
  end
endmodule